// File: doc/BRIEF.md
# Burst Column Order Generator with Mode Register

This block keeps the operating mode of a double-data-rate memory device and turns one column command into the column address sequence for a whole burst. A mode write carries a 13-bit operand that sets the burst length, the burst ordering and the read latency. Once a valid mode is held, a start strobe with a column address begins a burst. The block then presents one column address per clock, one for each data beat, until the programmed length has been covered or a terminate input stops it early.

The order of the beats is either wrap-around counting or XOR interleaving. In both cases it stays inside the block of columns that is aligned to the burst length. Only the low log2(length) address bits are reordered, and the bits above them pass through unchanged. A controller places this block between its command decoder and its column path. It drives the mode write and the burst start, and it uses the `cmd_ready` output to know when it may issue the next command.

The control is a three-state machine. `ST_IDLE` accepts commands. `ST_MRS_SETTLE` is the extra cycle that a mode write needs. `ST_BURST` emits the beats. The transitions are named as follows:
- write-accept: `ST_IDLE` to `ST_MRS_SETTLE`, on an accepted mode write.
- settle-done: `ST_MRS_SETTLE` to `ST_IDLE`, always after one cycle.
- burst-launch: `ST_IDLE` to `ST_BURST`, on a start with a valid mode and no mode write in the same cycle.
- burst-end: `ST_BURST` to `ST_IDLE`, on the last beat or on terminate.
- hold: the state stays where it is in every other case.

Top module: `burst_order_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `mode_valid`, `col_valid`, `burst_done` and `mrs_reject` are 0 and `cmd_ready` is 1.
- R2: A mode write is accepted when `cmd_ready` is high, `banks_idle` is high, operand bit 7 is 0 and operand bits 2:0 hold a supported length code. The codes are 001 for 2, 010 for 4, 011 for 8 and 100 for 16. In the cycle after acceptance, `burst_len` shows the length, `burst_interleave` shows operand bit 3 (0 is wrap-around, 1 is interleaved), `read_latency` shows operand bits 6:4, and `mode_valid` is 1.
- R3: A mode write that is offered while `cmd_ready` is high but fails a check is ignored. The failing cases are a reserved length code, bit 7 set, or `banks_idle` low. In the cycle after such a write, `mrs_reject` is 1 for exactly one cycle and all mode outputs keep their old values.
- R4: After an accepted mode write, `cmd_ready` is 0 for one cycle. A start or a mode write offered in that cycle has no effect.
- R5: A start while `mode_valid` is 0 produces no beats.
- R6: In wrap-around mode, beat i carries the low offset (start offset + i) mod length.
- R7: In interleaved mode, beat i carries the low offset start offset XOR i.
- R8: The column bits above the low log2(length) bits equal those of `start_col` on every beat.
- R9: A burst that starts at the clock edge where start is sampled shows beat 0 in the following cycle. Exactly `burst_len` beats are shown, `beat_idx` counts up from 0, `burst_done` is high only on the last beat, and `cmd_ready` returns in the cycle after that beat.
- R10: A terminate input that is high during a beat makes that beat the last one. `burst_done` is high in that cycle and `col_valid` is 0 in the next cycle.
- R11: A start that arrives during a burst is ignored. The running burst keeps its order and no second burst follows.
- R12: When a mode write and a start arrive in the same ready cycle, the mode write is processed and the start is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mrs_valid | input | 1 | Mode write strobe |
| mrs_op | input | 13 | Mode write operand |
| banks_idle | input | 1 | High when all banks are precharged |
| start | input | 1 | Burst start strobe |
| start_col | input | 10 | Starting column address |
| terminate | input | 1 | Ends the running burst after the current beat |
| cmd_ready | output | 1 | High when a new command may be issued |
| mode_valid | output | 1 | A legal mode has been written |
| mrs_reject | output | 1 | One-cycle flag for an ignored mode write |
| burst_len | output | 5 | Programmed burst length in beats |
| burst_interleave | output | 1 | Programmed order, 1 means interleaved |
| read_latency | output | 3 | Programmed read latency field |
| col_valid | output | 1 | A beat address is present |
| col_addr | output | 10 | Column address of the current beat |
| beat_idx | output | 4 | Index of the current beat |
| burst_done | output | 1 | Last beat of the burst |

## Verification
The hardest condition to produce from the ports is a command that arrives during the one-cycle settle window after a mode write. The only way to hit that window is to assert start, or a second mode write, in the exact cycle where `cmd_ready` has just fallen. The bench does this by driving the strobe at the falling clock edge that follows the accepted write. It then confirms that no beat appears and that the mode outputs keep the first write's values. Early termination and a start that arrives in the middle of a burst are set up the same way: the bench drives the input at the falling edge of a chosen beat and checks the beats that follow.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int OP_W     = 13;
    localparam int MAX_LOG2 = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MRS_SETTLE,
        ST_BURST
    } seq_state_t;

    typedef struct packed {
        logic [2:0] len_log2;
        logic       interleave;
        logic [2:0] rd_lat;
    } mode_cfg_t;

    // Returns log2 of the burst length, or 0 for a reserved code.
    function automatic logic [2:0] decode_len(input logic [2:0] code);
        logic [2:0] r;
        unique case (code)
            3'b001:  r = 3'd1;
            3'b010:  r = 3'd2;
            3'b011:  r = 3'd3;
            3'b100:  r = 3'd4;
            default: r = 3'd0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/burst_mode_reg.sv
module burst_mode_reg
    import burst_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_req,
    input  logic [OP_W-1:0] op,
    input  logic            banks_idle,
    output mode_cfg_t       cfg,
    output logic            cfg_valid,
    output logic            accept,
    output logic            reject
);

    logic [2:0] len_dec;
    mode_cfg_t  cfg_q;
    logic       valid_q;
    logic       reject_q;

    always_comb begin
        len_dec = decode_len(op[2:0]);
        accept  = wr_req && banks_idle && !op[7] && (len_dec != 3'd0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q    <= '0;
            valid_q  <= 1'b0;
            reject_q <= 1'b0;
        end else begin
            reject_q <= wr_req && !accept;
            if (accept) begin
                cfg_q.len_log2   <= len_dec;
                cfg_q.interleave <= op[3];
                cfg_q.rd_lat     <= op[6:4];
                valid_q          <= 1'b1;
            end
        end
    end

    assign cfg       = cfg_q;
    assign cfg_valid = valid_q;
    assign reject    = reject_q;

    // The write that raised the flag must have left the mode untouched.
    assert_reject_keeps_cfg_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reject_q |-> ($stable(cfg_q) && $stable(valid_q)));

endmodule

// File: rtl/burst_beat_gen.sv
module burst_beat_gen
    import burst_seq_pkg::*;
#(
    parameter int COL_W  = 10,
    parameter int BEAT_W = MAX_LOG2
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              run,
    input  logic [COL_W-1:0]  start_col,
    input  logic [2:0]        len_log2,
    input  logic              interleave,
    output logic [COL_W-1:0]  col_addr,
    output logic [BEAT_W-1:0] beat_idx,
    output logic              last
);

    localparam int PAD_W = COL_W - BEAT_W;

    logic [COL_W-1:0]  base_q;
    logic [BEAT_W-1:0] beat_q;
    logic [2:0]        len_q;
    logic              il_q;
    logic [COL_W-1:0]  mask;
    logic [BEAT_W-1:0] beat_mask;
    logic [COL_W-1:0]  beat_ext;
    logic [COL_W-1:0]  low_part;

    always_comb begin
        mask      = ~({COL_W{1'b1}} << len_q);
        beat_mask = ~({BEAT_W{1'b1}} << len_q);
        beat_ext  = {{PAD_W{1'b0}}, beat_q};
        if (il_q) low_part = (base_q ^ beat_ext) & mask;
        else      low_part = (base_q + beat_ext) & mask;
        col_addr = (base_q & ~mask) | low_part;
        beat_idx = beat_q;
        last     = (beat_q == beat_mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            beat_q <= '0;
            len_q  <= 3'd1;
            il_q   <= 1'b0;
        end else if (load) begin
            base_q <= start_col;
            beat_q <= '0;
            len_q  <= len_log2;
            il_q   <= interleave;
        end else if (run) begin
            beat_q <= beat_q + 1'b1;
        end
    end

    // Wrap-around order steps the low offset by one between beats.
    assert_seq_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !$past(last) && !il_q)
        |-> ((col_addr & mask) == (($past(col_addr) + 1'b1) & mask)));

    // Interleaved order differs from the start by exactly the beat index.
    assert_xor_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && il_q) |-> (((col_addr ^ base_q) & mask) == beat_ext));

endmodule

// File: rtl/burst_order_seq.sv
module burst_order_seq
    import burst_seq_pkg::*;
#(
    parameter int COL_W = 10
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mrs_valid,
    input  logic [12:0]      mrs_op,
    input  logic             banks_idle,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic             terminate,
    output logic             cmd_ready,
    output logic             mode_valid,
    output logic             mrs_reject,
    output logic [4:0]       burst_len,
    output logic             burst_interleave,
    output logic [2:0]       read_latency,
    output logic             col_valid,
    output logic [COL_W-1:0] col_addr,
    output logic [3:0]       beat_idx,
    output logic             burst_done
);

    seq_state_t state_q, state_d;
    mode_cfg_t  cfg;
    logic       mrs_accept;
    logic       wr_req;
    logic       launch;
    logic       beat_last;

    assign wr_req = mrs_valid && (state_q == ST_IDLE);
    assign launch = (state_q == ST_IDLE) && start && mode_valid && !mrs_valid;

    burst_mode_reg u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_req     (wr_req),
        .op         (mrs_op),
        .banks_idle (banks_idle),
        .cfg        (cfg),
        .cfg_valid  (mode_valid),
        .accept     (mrs_accept),
        .reject     (mrs_reject)
    );

    burst_beat_gen #(.COL_W(COL_W), .BEAT_W(MAX_LOG2)) u_beats (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (launch),
        .run        (col_valid),
        .start_col  (start_col),
        .len_log2   (cfg.len_log2),
        .interleave (cfg.interleave),
        .col_addr   (col_addr),
        .beat_idx   (beat_idx),
        .last       (beat_last)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (mrs_accept)  state_d = ST_MRS_SETTLE;
                else if (launch) state_d = ST_BURST;
            end
            ST_MRS_SETTLE: state_d = ST_IDLE;
            ST_BURST: begin
                if (beat_last || terminate) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        cmd_ready        = (state_q == ST_IDLE);
        col_valid        = (state_q == ST_BURST);
        burst_done       = col_valid && (beat_last || terminate);
        burst_len        = 5'd1 << cfg.len_log2;
        burst_interleave = cfg.interleave;
        read_latency     = cfg.rd_lat;
    end

    assert_settle_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mrs_accept |=> !cmd_ready);

    assert_no_beats_unprogrammed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_valid |-> !col_valid);

    assert_done_on_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |-> col_valid);

    assert_done_ends_burst_R10: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |=> (!col_valid && cmd_ready));

    assert_beat_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid |-> ({1'b0, beat_idx} < burst_len));

endmodule

// File: tb/burst_order_seq_test.sv
module burst_order_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mrs_valid = 1'b0;
    logic [12:0] mrs_op = '0;
    logic        banks_idle = 1'b1;
    logic        start = 1'b0;
    logic [9:0]  start_col = '0;
    logic        terminate = 1'b0;
    logic        cmd_ready, mode_valid, mrs_reject, burst_interleave;
    logic        col_valid, burst_done;
    logic [4:0]  burst_len;
    logic [2:0]  read_latency;
    logic [9:0]  col_addr;
    logic [3:0]  beat_idx;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    always #10 clk = ~clk;

    burst_order_seq #(.COL_W(10)) uut (
        .clk(clk), .rst_n(rst_n), .mrs_valid(mrs_valid), .mrs_op(mrs_op),
        .banks_idle(banks_idle), .start(start), .start_col(start_col),
        .terminate(terminate), .cmd_ready(cmd_ready), .mode_valid(mode_valid),
        .mrs_reject(mrs_reject), .burst_len(burst_len),
        .burst_interleave(burst_interleave), .read_latency(read_latency),
        .col_valid(col_valid), .col_addr(col_addr), .beat_idx(beat_idx),
        .burst_done(burst_done)
    );

    // Table entries: {interleave, length code, start column}.
    localparam logic [13:0] VEC [8] = '{
        {1'b0, 3'b010, 10'h001},
        {1'b1, 3'b011, 10'h005},
        {1'b0, 3'b001, 10'h3FF},
        {1'b1, 3'b100, 10'h2A7},
        {1'b0, 3'b100, 10'h12E},
        {1'b1, 3'b010, 10'h0D2},
        {1'b0, 3'b011, 10'h35D},
        {1'b1, 3'b001, 10'h101}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d (0x%0h), expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    function automatic int exp_col(input bit il, input int len, input int s, input int i);
        int blk = s - (s % len);
        int off = s % len;
        if (il) return blk + (off ^ i);
        return blk + ((off + i) % len);
    endfunction

    function automatic logic [12:0] mk_op(input bit tbit, input int lat, input bit il,
                                          input logic [2:0] code);
        return {5'b0, tbit, 3'(lat), il, code};
    endfunction

    task automatic mrs_write(input logic [12:0] op, input bit idle);
        @(negedge clk);
        mrs_valid  = 1'b1;
        mrs_op     = op;
        banks_idle = idle;
        @(negedge clk);
        mrs_valid  = 1'b0;
        banks_idle = 1'b1;
    endtask

    task automatic run_burst(input bit il, input logic [2:0] code, input int s);
        int len = 1 << code;
        @(negedge clk);
        start     = 1'b1;
        start_col = 10'(s);
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < len; i++) begin
            chk("R9 col_valid", int'(col_valid), 1);
            chk(il ? "R7 interleaved col_addr" : "R6 sequential col_addr",
                int'(col_addr), exp_col(il, len, s, i));
            chk("R8 upper bits", int'(col_addr) / len, s / len);
            chk("R9 beat_idx", int'(beat_idx), i);
            chk("R9 burst_done", int'(burst_done), (i == len - 1) ? 1 : 0);
            @(negedge clk);
        end
        chk("R9 end col_valid", int'(col_valid), 0);
        chk("R9 end cmd_ready", int'(cmd_ready), 1);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 mode_valid", int'(mode_valid), 0);
        chk("R1 col_valid", int'(col_valid), 0);
        chk("R1 cmd_ready", int'(cmd_ready), 1);
        chk("R1 burst_done", int'(burst_done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 mrs_reject after reset", int'(mrs_reject), 0);

        // R5: start before any mode write
        start = 1'b1; start_col = 10'h010;
        @(negedge clk);
        start = 1'b0;
        chk("R5 no beat when unprogrammed", int'(col_valid), 0);
        @(negedge clk);
        chk("R5 still no beat", int'(col_valid), 0);

        // R3: rejected writes before any legal one
        mrs_write(mk_op(0, 3, 0, 3'b101), 1);
        chk("R3 reserved code flagged", int'(mrs_reject), 1);
        chk("R3 reserved code ignored", int'(mode_valid), 0);
        @(negedge clk);
        chk("R3 flag lasts one cycle", int'(mrs_reject), 0);

        // R2: field capture
        mrs_write(mk_op(0, 5, 1, 3'b010), 1);
        chk("R2 mode_valid", int'(mode_valid), 1);
        chk("R2 burst_len", int'(burst_len), 4);
        chk("R2 interleave", int'(burst_interleave), 1);
        chk("R2 read_latency", int'(read_latency), 5);
        chk("R2 no reject", int'(mrs_reject), 0);
        chk("R4 cmd_ready low in settle", int'(cmd_ready), 0);
        // R4: commands during the settle cycle have no effect
        start = 1'b1; start_col = 10'h020;
        mrs_valid = 1'b1; mrs_op = mk_op(0, 3, 0, 3'b001);
        @(negedge clk);
        start = 1'b0; mrs_valid = 1'b0;
        chk("R4 start ignored in settle", int'(col_valid), 0);
        chk("R4 write ignored in settle", int'(burst_len), 4);
        chk("R4 no flag in settle", int'(mrs_reject), 0);
        chk("R4 cmd_ready back", int'(cmd_ready), 1);

        // R3: test bit and busy banks keep the old mode
        mrs_write(mk_op(1, 3, 0, 3'b011), 1);
        chk("R3 test bit flagged", int'(mrs_reject), 1);
        chk("R3 test bit ignored", int'(burst_len), 4);
        mrs_write(mk_op(0, 3, 0, 3'b011), 0);
        chk("R3 busy banks flagged", int'(mrs_reject), 1);
        chk("R3 busy banks ignored", int'(read_latency), 5);
        chk("R3 busy banks order kept", int'(burst_interleave), 1);

        // Vector table: R6, R7, R8, R9
        for (int v = 0; v < 8; v++) begin
            logic [13:0] e = VEC[v];
            mrs_write(mk_op(0, 3, e[13], e[12:10]), 1);
            @(negedge clk);
            chk("R2 table burst_len", int'(burst_len), 1 << e[12:10]);
            chk("R2 table read_latency", int'(read_latency), 3);
            run_burst(e[13], e[12:10], int'(e[9:0]));
        end

        // R12: mode write and start together
        @(negedge clk);
        mrs_valid = 1'b1; mrs_op = mk_op(0, 3, 0, 3'b011);
        start = 1'b1; start_col = 10'h010;
        @(negedge clk);
        mrs_valid = 1'b0; start = 1'b0;
        chk("R12 start dropped", int'(col_valid), 0);
        chk("R12 write taken", int'(burst_len), 8);
        @(negedge clk);
        chk("R12 still no beat", int'(col_valid), 0);

        // R10: terminate on beat 2 of an 8-beat wrap-around burst
        start = 1'b1; start_col = 10'h013;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk("R10 beat before stop", int'(col_addr), exp_col(0, 8, 'h013, i));
            if (i == 2) begin
                terminate = 1'b1;
                #1;
                chk("R10 done on terminate", int'(burst_done), 1);
            end else begin
                chk("R10 not done early", int'(burst_done), 0);
            end
            @(negedge clk);
        end
        terminate = 1'b0;
        chk("R10 no beat after terminate", int'(col_valid), 0);
        chk("R10 ready after terminate", int'(cmd_ready), 1);

        // R11: start in mid-burst is ignored
        mrs_write(mk_op(0, 3, 0, 3'b010), 1);
        @(negedge clk);
        start = 1'b1; start_col = 10'h042;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 4; i++) begin
            chk("R11 order kept", int'(col_addr), exp_col(0, 4, 'h042, i));
            chk("R11 beat_idx", int'(beat_idx), i);
            start = (i == 1 || i == 2);
            start_col = 10'h0FF;
            @(negedge clk);
        end
        start = 1'b0;
        chk("R11 no second burst", int'(col_valid), 0);
        @(negedge clk);
        chk("R11 still idle", int'(col_valid), 0);

        finish_run();
    end

endmodule